// File: doc/BRIEF.md
# Stereo Clip Indicator with Mode-Scaled Hold

This block turns per-channel over-range indications from an audio decimation path into two active-high clip flags, one for the left channel and one for the right. A channel's flag goes high on the clock edge that accepts an over-range sample. It then stays high for a hold interval that is counted in output sample periods. It falls when that interval has passed with no new over-range on that channel. The flags are meant to drive front-panel clip lamps, so the hold is long enough to be seen.

The hold interval is tied to the sampling-rate mode. Faster sample rates use a proportionally longer count, so the lamp time stays roughly constant in seconds. The block only operates while the converter produces linear PCM. When the one-bit stream output is selected, both flags are forced low and both hold timers are cleared. Detecting full scale is done upstream. This block only receives the result, one over-range bit per channel, each qualified by a shared sample strobe.

Top module: `clip_hold_detector`

## Requirements
- R1: While reset (`rstN` low) is asserted, and on the first sample after it is released, both flags are low.
- R2: A clock edge on which `sampleStb` is high, `dsdMode` is low and a channel's over-range input is high drives that channel's flag high from that edge on.
- R3: An over-range input that is high while `sampleStb` is low is ignored: no flag rises.
- R4: After the setting sample, a flag stays high through HOLD-1 further non-over-range strobes and goes low on the edge of the HOLD-th one. HOLD is HOLD_SCALE×128 for `rateMode` 0 (single rate), HOLD_SCALE×256 for 1 (dual rate) and HOLD_SCALE×512 for 2 (quad rate). The default HOLD_SCALE is 256.
- R5: `rateMode` value 3 uses the same hold length as quad rate.
- R6: An over-range strobe on a channel whose flag is already high reloads that channel's full hold length.
- R7: The two channels are independent: an event or a countdown on one never changes the other flag.
- R8: While `dsdMode` is high, both flags are low and over-range strobes are ignored. Leaving that mode does not bring back a flag that was cleared.
- R9: Clock edges without `sampleStb` do not advance the hold countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | One-cycle strobe per output sample period |
| overLeft | input | 1 | Left over-range indication, valid with `sampleStb` |
| overRight | input | 1 | Right over-range indication, valid with `sampleStb` |
| rateMode | input | 2 | 0 single, 1 dual, 2 or 3 quad rate |
| dsdMode | input | 1 | High when the one-bit stream output is selected |
| clipLeft | output | 1 | Left clip flag, active high |
| clipRight | output | 1 | Right clip flag, active high |

## Verification
The hardest behaviour to reach from the ports is the exact edge where a hold runs out. This edge lies thousands of strobes after the event, and its position depends on the mode. A retrigger moves it again. The bench builds the design with a small HOLD_SCALE so the interval shrinks while keeping its per-mode ratios. It holds `sampleStb` high for a counted number of cycles, then samples each flag one strobe before and exactly at the expected fall. For the retrigger case, a second event is placed partway through the countdown, and the flag is checked against the reloaded length, not the first one.

// File: rtl/clip_hold_pkg.sv
package clip_hold_pkg;

  // rate selection as seen on the rateMode port
  typedef enum logic [1:0] {
    RATE_SINGLE   = 2'd0,
    RATE_DUAL     = 2'd1,
    RATE_QUAD     = 2'd2,
    RATE_QUAD_ALT = 2'd3
  } rateSel_t;

  // per-channel command from control to datapath
  typedef struct packed {
    logic load;   // reload the hold length
    logic step;   // count one elapsed sample period
  } chanCmd_t;

  // hold length in single rate is HOLD_SCALE << BASE_SHIFT
  localparam int BASE_SHIFT = 7;

endpackage

// File: rtl/clip_hold_ctrl.sv
module clip_hold_ctrl
  import clip_hold_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int HOLD_SCALE = 256,
  parameter int CNT_W      = 18
) (
  input  logic                       sampleStb,
  input  logic [NUM_CH-1:0]          overVec,
  input  rateSel_t                   rateSel,
  input  logic                       dsdMode,
  input  logic [NUM_CH-1:0]          activeVec,
  output chanCmd_t [NUM_CH-1:0]      cmd,
  output logic                       clearAll,
  output logic [CNT_W-1:0]           holdLen
);

  localparam int HOLD_SINGLE = HOLD_SCALE << BASE_SHIFT;
  localparam int HOLD_DUAL   = HOLD_SCALE << (BASE_SHIFT + 1);
  localparam int HOLD_QUAD   = HOLD_SCALE << (BASE_SHIFT + 2);

  always_comb begin
    unique case (rateSel)
      RATE_SINGLE: holdLen = CNT_W'(HOLD_SINGLE);
      RATE_DUAL:   holdLen = CNT_W'(HOLD_DUAL);
      default:     holdLen = CNT_W'(HOLD_QUAD);
    endcase
  end

  assign clearAll = dsdMode;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmd
    logic accepted;
    assign accepted        = sampleStb & ~dsdMode;
    assign cmd[ch].load    = accepted & overVec[ch];
    assign cmd[ch].step    = accepted & ~overVec[ch] & activeVec[ch];
  end

endmodule

// File: rtl/clip_hold_dp.sv
module clip_hold_dp
  import clip_hold_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 18
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCmd_t [NUM_CH-1:0] cmd,
  input  logic                  clearAll,
  input  logic [CNT_W-1:0]      holdLen,
  output logic [NUM_CH-1:0]     activeVec
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        remain <= '0;
      end else if (clearAll) begin
        remain <= '0;
      end else if (cmd[ch].load) begin
        remain <= holdLen;
      end else if (cmd[ch].step && (remain != '0)) begin
        remain <= remain - CNT_W'(1);
      end
    end

    assign activeVec[ch] = (remain != '0);
  end

endmodule

// File: rtl/clip_hold_detector.sv
module clip_hold_detector
  import clip_hold_pkg::*;
#(
  parameter int HOLD_SCALE = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStb,
  input  logic       overLeft,
  input  logic       overRight,
  input  logic [1:0] rateMode,
  input  logic       dsdMode,
  output logic       clipLeft,
  output logic       clipRight
);

  localparam int NUM_CH = 2;
  localparam int CNT_W  = $clog2((HOLD_SCALE << (BASE_SHIFT + 2)) + 1);

  chanCmd_t [NUM_CH-1:0] cmd;
  logic                  clearAll;
  logic [CNT_W-1:0]      holdLen;
  logic [NUM_CH-1:0]     activeVec;

  clip_hold_ctrl #(
    .NUM_CH    (NUM_CH),
    .HOLD_SCALE(HOLD_SCALE),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .sampleStb(sampleStb),
    .overVec  ({overRight, overLeft}),
    .rateSel  (rateSel_t'(rateMode)),
    .dsdMode  (dsdMode),
    .activeVec(activeVec),
    .cmd      (cmd),
    .clearAll (clearAll),
    .holdLen  (holdLen)
  );

  clip_hold_dp #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .clearAll (clearAll),
    .holdLen  (holdLen),
    .activeVec(activeVec)
  );

  assign clipLeft  = activeVec[0];
  assign clipRight = activeVec[1];

endmodule

// File: rtl/clip_hold_checker.sv
module clip_hold_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleStb,
  input logic       overLeft,
  input logic       overRight,
  input logic       dsdMode,
  input logic       clipLeft,
  input logic       clipRight
);

  assert_rise_left_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && overLeft && !dsdMode) |=> clipLeft);

  assert_rise_right_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && overRight && !dsdMode) |=> clipRight);

  assert_dsd_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    dsdMode |=> (!clipLeft && !clipRight));

  assert_no_strobe_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStb && !dsdMode) |=> ($stable(clipLeft) && $stable(clipRight)));

  assert_fall_on_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(clipLeft) || $fell(clipRight)) |-> ($past(sampleStb) || $past(dsdMode)));

  assert_no_stray_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clipLeft) |-> ($past(sampleStb) && $past(overLeft)));

endmodule

bind clip_hold_detector clip_hold_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sampleStb(sampleStb),
  .overLeft (overLeft),
  .overRight(overRight),
  .dsdMode  (dsdMode),
  .clipLeft (clipLeft),
  .clipRight(clipRight)
);

// File: tb/sim_clip_hold_detector.sv
`timescale 1ns/1ps
module sim_clip_hold_detector;

  localparam int SCALE = 4;
  localparam int HS = SCALE * 128;   // single-rate hold
  localparam int HD = SCALE * 256;   // dual-rate hold
  localparam int HQ = SCALE * 512;   // quad-rate hold

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleStb = 1'b0;
  logic       overLeft = 1'b0;
  logic       overRight = 1'b0;
  logic [1:0] rateMode = 2'd0;
  logic       dsdMode = 1'b0;
  logic       clipLeft;
  logic       clipRight;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clip_hold_detector #(.HOLD_SCALE(SCALE)) u0 (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .overLeft(overLeft), .overRight(overRight),
    .rateMode(rateMode), .dsdMode(dsdMode),
    .clipLeft(clipLeft), .clipRight(clipRight)
  );

  // fields: rate[22:21] dsd[20] oL[19] oR[18] eL[17] eR[16] idleStrobes[15:0]
  localparam logic [22:0] VEC [10] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'(HS-1)},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'(HS)},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'(HD-1)},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'(HD)},
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'(HQ-1)},
    {2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'(HQ)},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'(HQ-1)},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'(HQ)},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd0},
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'd0}
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleStb = 1'b0; overLeft = 1'b0; overRight = 1'b0; dsdMode = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic event1(input logic oL, input logic oR);
    @(negedge clk);
    sampleStb = 1'b1; overLeft = oL; overRight = oR;
    @(negedge clk);
    sampleStb = 1'b0; overLeft = 1'b0; overRight = 1'b0;
  endtask

  task automatic idleStrobes(input int n);
    if (n > 0) begin
      @(negedge clk);
      sampleStb = 1'b1;
      repeat (n) @(negedge clk);
      sampleStb = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 left in reset", clipLeft, 1'b0);
    check("R1 right in reset", clipRight, 1'b0);
    rstN = 1'b1;
    idleStrobes(1);
    check("R1 left after release", clipLeft, 1'b0);

    // table walk: R4 mode lengths, R5 alt quad, R8 dsd, R2/R7 independence
    for (int i = 0; i < 10; i++) begin
      doReset();
      rateMode = VEC[i][22:21];
      dsdMode  = VEC[i][20];
      event1(VEC[i][19], VEC[i][18]);
      idleStrobes(int'(VEC[i][15:0]));
      check($sformatf("R4 R5 R8 R2 R7 vec%0d left", i), clipLeft, VEC[i][17]);
      check($sformatf("R4 R5 R8 R2 R7 vec%0d right", i), clipRight, VEC[i][16]);
      dsdMode = 1'b0;
    end

    // R3: over-range without strobe is ignored
    doReset();
    rateMode = 2'd0;
    @(negedge clk);
    overLeft = 1'b1; overRight = 1'b1;
    repeat (4) @(negedge clk);
    overLeft = 1'b0; overRight = 1'b0;
    check("R3 left", clipLeft, 1'b0);
    check("R3 right", clipRight, 1'b0);

    // R9: edges without strobe do not count down
    doReset();
    event1(1'b1, 1'b0);
    repeat (HS + 20) @(negedge clk);
    check("R9 still high after idle clocks", clipLeft, 1'b1);
    idleStrobes(HS - 1);
    check("R9 high one strobe before end", clipLeft, 1'b1);
    idleStrobes(1);
    check("R9 low at end", clipLeft, 1'b0);

    // R6: retrigger reloads full length; R7 other channel untouched
    doReset();
    event1(1'b1, 1'b0);
    idleStrobes(300);
    event1(1'b1, 1'b0);
    idleStrobes(300);
    check("R6 high past first expiry", clipLeft, 1'b1);
    check("R7 right untouched", clipRight, 1'b0);
    idleStrobes(HS - 301);
    check("R6 high one before reloaded end", clipLeft, 1'b1);
    idleStrobes(1);
    check("R6 low at reloaded end", clipLeft, 1'b0);

    // R8: dsd clears a live flag, no return after leaving
    doReset();
    event1(1'b1, 1'b1);
    check("R8 set before dsd", clipRight, 1'b1);
    @(negedge clk); dsdMode = 1'b1;
    @(negedge clk);
    check("R8 left cleared in dsd", clipLeft, 1'b0);
    check("R8 right cleared in dsd", clipRight, 1'b0);
    dsdMode = 1'b0;
    idleStrobes(3);
    check("R8 left stays low after dsd", clipLeft, 1'b0);

    finishRun();
  end

endmodule